// File: doc/BRIEF.md
# Multi-Mode Host Register Bus Slave

This block lets a host processor read and write a small bank of eight 8-bit registers. A two-bit mode input selects one of three bus styles:

- **Split-strobe asynchronous style**: chip select with separate read and write strobes.
- **Single-strobe asynchronous style**: chip select, one data strobe, and a read/not-write level.
- **Clocked style**: access requests are sampled on the block clock.

Each style finishes an access through the same handshake output. The meaning and polarity of that output depend on the mode. The processor stretches its cycle for as long as the handshake stays at its inactive level.

A programmable wait count of 0 to 7 clocks delays the acknowledge, so slow register timing can be modelled. Register 7 is a read-only status register that follows an external status input. A write to it is acknowledged but changes nothing. Registers 0 to 6 are read/write and have fixed defaults.

The active-low reset clears the block asynchronously and its release is synchronised to the clock. While reset is active, both output enables are low, so the pads float.

Top module: `hostbus_slave`

## Requirements
- R1: After reset release, registers 0 to 6 read back their defaults, where register i holds (i*0x1E + 0x0F) mod 256 (0x0F, 0x2D, 0x4B, 0x69, 0x87, 0xA5, 0xC3).
- R2: With mode 0, an access starts when cs_n and rd_n (read) or wr_n (write) are low; rd_n wins if both are low. The handshake is active low and idles high.
- R3: With mode 1, an access starts when cs_n and ds_n are low; rnw=1 reads and rnw=0 writes. The handshake is active low and idles high.
- R4: With mode 2 or 3, an access starts on a clock edge that samples cs_n low, with rnw giving the direction. The handshake is active high, idles low, and is high for exactly one clock per access.
- R5: The handshake turns active exactly 4+W clocks after the strobes are applied in modes 0 and 1 (two synchroniser stages included), and exactly 2+W clocks after cs_n is applied in the clocked mode. W is the value on wait_cnt.
- R6: In modes 0 and 1, the handshake stays active while the strobe stays asserted. It returns inactive exactly 3 clocks after the strobe is released.
- R7: rdata_oe is high only while a read is being acknowledged, and rdata then carries the addressed register. rdata_oe is low while idle, while waiting, and during writes.
- R8: A write stores wdata into the addressed register among 0 to 6, and a later read returns it.
- R9: A write to address 7 is acknowledged normally but leaves it unchanged. Reads of address 7 return the status input.
- R10: While rst_n is low, ack_oe and rdata_oe are low. Once reset has been released, ack_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the processor clock in the clocked mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Bus style: 0 split strobes, 1 data strobe, 2/3 clocked |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, mode 0 |
| wr_n | input | 1 | Write strobe, mode 0 |
| ds_n | input | 1 | Data strobe, mode 1 |
| rnw | input | 1 | Read (1) or write (0), modes 1 to 3 |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wait_cnt | input | 3 | Wait clocks before acknowledge |
| status_in | input | 8 | Source of read-only register 7 |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data pad enable |
| ack | output | 1 | Handshake, polarity set by mode |
| ack_oe | output | 1 | Handshake pad enable |

## Verification
A corrupted access state or wait counter shows on ack within the access itself. The acknowledge arrives a clock early or late, never arrives, or fails to drop after the strobe is released. Each access measures these to the exact clock. A wrong latched direction or address shows as rdata_oe set during a write, or as the wrong data on the same acknowledge. A register written with the wrong value stays hidden until the next read of that address, which the bench performs right after each write.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } acc_state_e;

  localparam logic [1:0] MODE_SPLIT = 2'd0;
  localparam logic [1:0] MODE_DSTRB = 2'd1;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL;
        s2_q <= RST_VAL;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl
  import hbs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              cs_s,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic              ds_s,
  input  logic              cs_raw,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              acc_we,
  output logic              acc_rd,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              ack_act,
  output logic              rd_active
);
  acc_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              isrd_q, isrd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              clocked, req, req_rd, fire;

  always_comb begin
    clocked = mode[1];
    if (clocked) begin
      req    = ~cs_raw;
      req_rd = rnw;
    end else if (mode == MODE_DSTRB) begin
      req    = ~cs_s & ~ds_s;
      req_rd = rnw;
    end else begin
      req    = ~cs_s & (~rd_s | ~wr_s);
      req_rd = ~rd_s;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    isrd_d  = isrd_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    fire    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        state_d = ST_WAIT;
        cnt_d   = wait_cnt;
        isrd_d  = req_rd;
        addr_d  = addr;
        wdat_d  = wdata;
      end
      ST_WAIT: if (cnt_q == '0) begin
        state_d = ST_ACK;
        fire    = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      ST_ACK: if (clocked || !req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      isrd_q  <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      isrd_q  <= isrd_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
    end
  end

  assign acc_we    = fire & ~isrd_q;
  assign acc_rd    = fire & isrd_q;
  assign acc_addr  = addr_q;
  assign acc_wdata = wdat_q;
  assign ack_act   = (state_q == ST_ACK);
  assign rd_active = ack_act & isrd_q;

  // R4: clocked-mode ready lasts a single clock
  p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clocked && ack_act) |=> !ack_act);
  // R6: asynchronous acknowledge holds while the strobe is asserted
  p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clocked && ack_act && req) |=> ack_act);
  // R6: asynchronous acknowledge drops only after the strobe has gone
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clocked && $fell(ack_act)) |-> !$past(req));
  // R5: acknowledge is reached only from an expired wait count
  p_wait_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_act) |-> ($past(state_q) == ST_WAIT && $past(cnt_q) == '0));
endmodule

// File: rtl/hbs_regs.sv
module hbs_regs #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              rd_load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rdata
);
  localparam int NREGS = 1 << ADDR_W;
  localparam int RO    = NREGS - 1;

  function automatic logic [DATA_W-1:0] dflt(input int unsigned idx);
    logic [31:0] v;
    v = idx * 32'h1E + 32'h0F;
    return v[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] regs_q [NREGS];
  logic [DATA_W-1:0] rdata_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == RO) begin : g_status
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[i] <= '0;
        else        regs_q[i] <= status_in;
      end
    end else begin : g_rw
      logic wen;
      assign wen = we && (addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs_q[i] <= dflt(i);
        else if (wen) regs_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_load) rdata_q <= regs_q[addr];
  end
  assign rdata = rdata_q;

  // R9: a write aimed at the status register leaves it tracking status_in
  p_ro_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(RO)) |=> (regs_q[RO] == $past(status_in)));
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hbs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ds_n,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              ack,
  output logic              ack_oe
);
  logic       rst_ok;
  logic [3:0] strb_s;
  logic       acc_we, acc_rd, ack_act, rd_active;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;

  hbs_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ok)
  );

  hbs_sync #(.W(4), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_ok), .d({ds_n, wr_n, rd_n, cs_n}), .q(strb_s)
  );

  hbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ok), .mode(mode),
    .cs_s(strb_s[0]), .rd_s(strb_s[1]), .wr_s(strb_s[2]), .ds_s(strb_s[3]),
    .cs_raw(cs_n), .rnw(rnw), .addr(addr), .wdata(wdata), .wait_cnt(wait_cnt),
    .acc_we(acc_we), .acc_rd(acc_rd), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .ack_act(ack_act), .rd_active(rd_active)
  );

  hbs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ok), .we(acc_we), .rd_load(acc_rd),
    .addr(acc_addr), .wdata(acc_wdata), .status_in(status_in), .rdata(rdata)
  );

  assign ack      = mode[1] ? ack_act : ~ack_act;
  assign ack_oe   = rst_ok;
  assign rdata_oe = rd_active & rst_ok;

  // R7: read data is only enabled while the handshake is at its active level
  p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    rdata_oe |-> (ack == mode[1]));
  // R10: pad enables are off while reset is held
  p_reset_oe_r10: assert property (@(posedge clk)
    !rst_n |-> (!ack_oe && !rdata_oe));
endmodule

// File: tb/hostbus_slave_test.sv
module hostbus_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rnw = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] wait_cnt = '0;
  logic [7:0] status_in = '0;
  logic [7:0] rdata;
  logic       rdata_oe, ack, ack_oe;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  hostbus_slave uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ds_n(ds_n), .rnw(rnw), .addr(addr), .wdata(wdata), .wait_cnt(wait_cnt),
    .status_in(status_in), .rdata(rdata), .rdata_oe(rdata_oe), .ack(ack), .ack_oe(ack_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic active();
    return mode[1] ? ack : ~ack;
  endfunction

  function automatic logic [7:0] dflt(input int i);
    return 8'((i * 32'h1E + 32'h0F) & 32'hFF);
  endfunction

  // One bus access; checks handshake timing (R5, R6, R4) and output enable (R7)
  task automatic access(input logic [1:0] md, input bit rd, input int a,
                        input logic [7:0] wd, input int w, output logic [7:0] rv);
    int n;
    rv = '0;
    @(negedge clk);
    mode = md; addr = 3'(a); wdata = wd; wait_cnt = 3'(w); rnw = rd;
    @(negedge clk);
    check(md[1] ? "R4 idle level" : "R2/R3 idle level", ack, md[1] ? 0 : 1);
    check("R7 oe idle", rdata_oe, 0);
    cs_n = 1'b0;
    if (md == 2'd0) begin rd_n = ~rd; wr_n = rd; end
    if (md == 2'd1) ds_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!active() && n < 40);
    check("R5 latency", n, md[1] ? 2 + w : 4 + w);
    check("R7 oe during access", rdata_oe, rd ? 1 : 0);
    rv = rdata;
    if (md[1]) begin
      cs_n = 1'b1;
      @(negedge clk);
      check("R4 ready one clock", active(), 0);
    end else begin
      @(negedge clk);
      check("R6 ack held", active(), 1);
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (active() && n < 40);
      check("R6 release clocks", n, 3);
    end
    check("R7 oe after", rdata_oe, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 ack_oe in reset", ack_oe, 0);
    check("R10 rdata_oe in reset", rdata_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 ack_oe after reset", ack_oe, 1);
    for (int i = 0; i < 7; i++) begin
      access(2'd0, 1'b1, i, 8'h00, 0, v);
      check("R1 default", v, dflt(i));
    end
  endtask

  task automatic t_split();
    logic [7:0] v;
    access(2'd0, 1'b0, 2, 8'hA5 ^ 8'h3C, 1, v);
    access(2'd0, 1'b1, 2, 8'h00, 2, v);
    check("R2 R8 split readback", v, 8'h99);
  endtask

  task automatic t_dstrobe();
    logic [7:0] v;
    access(2'd1, 1'b0, 5, 8'h5E, 0, v);
    access(2'd1, 1'b1, 5, 8'h00, 3, v);
    check("R3 R8 dstrobe readback", v, 8'h5E);
    access(2'd1, 1'b1, 4, 8'h00, 7, v);
    check("R3 untouched neighbour", v, dflt(4));
  endtask

  task automatic t_clocked();
    logic [7:0] v;
    access(2'd2, 1'b0, 1, 8'hC7, 0, v);
    access(2'd2, 1'b1, 1, 8'h00, 7, v);
    check("R4 R8 clocked readback", v, 8'hC7);
    access(2'd3, 1'b0, 0, 8'h12, 4, v);
    access(2'd3, 1'b1, 0, 8'h00, 0, v);
    check("R4 mode3 readback", v, 8'h12);
  endtask

  task automatic t_status();
    logic [7:0] v;
    status_in = 8'h3C;
    access(2'd0, 1'b0, 7, 8'hFF, 0, v);
    access(2'd0, 1'b1, 7, 8'h00, 0, v);
    check("R9 write ignored", v, 8'h3C);
    status_in = 8'h81;
    access(2'd2, 1'b1, 7, 8'h00, 1, v);
    check("R9 status follows input", v, 8'h81);
  endtask

  initial begin
    t_reset();
    t_split();
    t_dstrobe();
    t_clocked();
    t_status();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule